// File: doc/BRIEF.md
# Byte-level two-wire bus master

This block is a software-stepped master for an open-drain two-wire serial bus. Software writes a byte-wide control register to request one bus phase at a time: a start (or repeated start), one byte transfer, or a stop. When a start or a byte finishes, the engine parks the bus with the clock held low, raises a completion flag and publishes a fixed status code. Software then reads the status, loads the data register and writes the control register again with the flag bit at zero, which clears the flag and launches the next phase.

The first byte after a start is the address byte: a 7-bit target shifted up by one, with bit 0 set for a read. Bit 0 of that byte fixes the direction of the following bytes. On reads the engine returns an acknowledge for a byte only when the acknowledge-request bit was set in the control write that launched it, so software leaves it clear for the last byte. Both lines are driven through pull-low enables; an interrupt-control register holds the interrupt enable and two manual pull-low bits that software can use to clock a stuck target free and then form a release sequence by hand.

Top module: `twb_master`

## Requirements
- R1: After reset the status reads 0xF8, the completion flag (control read-back bit 3) is 0, the interrupt output is 0 and neither line is pulled low.
- R2: A control write with enable (bit 6) and start (bit 5) set while the bus is idle and the data line reads high generates a start condition, then sets the flag and reports status 0x08, with the clock line held low while the flag is set.
- R3: The first byte after a start is sent from the data register MSB first; on its acknowledge slot the status becomes 0x18 (bit 0 = 0, ACK), 0x20 (bit 0 = 0, no ACK) or 0x40 (bit 0 = 1, ACK).
- R4: After a write address, each byte launched by a control write of 0x40 is sent MSB first from the data register; an acknowledged byte reports 0x28 and an unacknowledged one 0x30.
- R5: After a read address, each launched byte is shifted in MSB first and readable in the data register; if bit 2 (acknowledge request) was set in the launching write the master pulls the data line low in the ninth clock and reports 0x50, otherwise it releases it and reports 0x58.
- R6: A start requested while a transfer is open (flag set) produces a repeated start and reports 0x10.
- R7: A control write with enable and stop (bit 4) set while the flag is set produces a stop condition, after which the status is 0xF8, the flag is 0 and both lines are released.
- R8: While the flag is set, a control write with flag bit 3 at 1 leaves the flag, status and bus unchanged; only a write with enable set and bit 3 at 0 clears the flag.
- R9: A start requested while the data line reads low is refused: the flag stays 0, the status stays 0xF8 and the master does not pull either line.
- R10: The interrupt output is high exactly when interrupt-register bit 6 is set and the flag is set.
- R11: Interrupt-register bit 9 pulls the clock line low and bit 8 pulls the data line low, independently of the engine.
- R12: A control write with enable (bit 6) clear is ignored: no bus activity, flag and status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (6 enable, 5 start, 4 stop, 3 flag, 2 ack request) |
| ctl_rdata | output | 8 | Control read-back: bit 3 flag, bit 2 ack request |
| dat_we | input | 1 | Data register write strobe (taken only between phases) |
| dat_wdata | input | 8 | Byte to send |
| dat_rdata | output | 8 | Data register: last byte sent or received |
| int_we | input | 1 | Interrupt-control register write strobe |
| int_wdata | input | 10 | Bit 9 clock pull-low, bit 8 data pull-low, bit 6 interrupt enable |
| status | output | 8 | Status code of the last completed phase |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_in | input | 1 | Sensed level of the data line |

## Verification
The assertions assume software obeys the stepping protocol: control writes that launch a phase arrive only while the flag is set or the bus is idle, and the manual pull-low bits are not used while the engine is running a phase, since the line checks look only at the engine's own pull-low drive. The bench keeps to this by polling the flag or the idle status before every new command, by exercising the override bits only with the bus idle, and by modelling the target as a wired-AND party that changes the data line only while the clock is low.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_STOP  = 2'd1,
        PH_BIT   = 2'd2
    } ph_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_START = 3'd2,
        ST_BYTE  = 3'd3,
        ST_STOP  = 3'd4
    } eng_st_e;

    // control register bit positions
    localparam int CB_EN  = 6;
    localparam int CB_STA = 5;
    localparam int CB_STP = 4;
    localparam int CB_FLG = 3;
    localparam int CB_AAK = 2;

    // interrupt-control register bit positions
    localparam int IB_IEN   = 6;
    localparam int IB_SDAOV = 8;
    localparam int IB_SCLOV = 9;

    // status codes
    localparam logic [7:0] SC_START      = 8'h08;
    localparam logic [7:0] SC_RSTART     = 8'h10;
    localparam logic [7:0] SC_WADDR_ACK  = 8'h18;
    localparam logic [7:0] SC_WADDR_NAK  = 8'h20;
    localparam logic [7:0] SC_WDATA_ACK  = 8'h28;
    localparam logic [7:0] SC_WDATA_NAK  = 8'h30;
    localparam logic [7:0] SC_RADDR_ACK  = 8'h40;
    localparam logic [7:0] SC_RADDR_NAK  = 8'h48;
    localparam logic [7:0] SC_RDATA_ACK  = 8'h50;
    localparam logic [7:0] SC_RDATA_NAK  = 8'h58;
    localparam logic [7:0] SC_IDLE       = 8'hF8;

    typedef struct packed {
        logic       active;
        ph_cmd_e    cmd;
        logic [1:0] q;
        logic       tx;
        logic       rx;
        logic       scl_lo;
        logic       sda_lo;
    } phy_s;

    typedef struct packed {
        eng_st_e    st;
        logic       flag;
        logic [7:0] status;
        logic       aak;
        logic       ien;
        logic [1:0] ovr;
        logic [7:0] data;
        logic       txn;
        logic       first;
        logic       rd;
        logic [3:0] bitcnt;
        logic       issued;
    } eng_s;

endpackage

// File: rtl/twb_qtimer.sv
module twb_qtimer #(
    parameter int QTR_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/twb_bitphy.sv
module twb_bitphy
    import twb_pkg::*;
#(
    parameter int QTR_CYC = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  ph_cmd_e cmd,
    input  logic    tx_bit,
    input  logic    sda_in,
    output logic    done,
    output logic    rx_bit,
    output logic    scl_lo,
    output logic    sda_lo
);
    localparam phy_s PHY_RST = '{active: 1'b0, cmd: PH_START, q: 2'd0,
                                 tx: 1'b1, rx: 1'b1, scl_lo: 1'b0, sda_lo: 1'b0};

    phy_s r_q, r_d;
    logic tick;

    twb_qtimer #(.QTR_CYC(QTR_CYC)) u_qtimer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.active),
        .tick (tick)
    );

    // {clock pull-low, data pull-low} for each quarter of a phase
    function automatic logic [1:0] line_plan(ph_cmd_e c, logic [1:0] q, logic tx);
        logic [1:0] v;
        case (c)
            PH_START: case (q)
                2'd0:    v = 2'b10;
                2'd1:    v = 2'b00;
                2'd2:    v = 2'b01;
                default: v = 2'b11;
            endcase
            PH_STOP: case (q)
                2'd0:    v = 2'b11;
                2'd1:    v = 2'b01;
                2'd2:    v = 2'b01;
                default: v = 2'b00;
            endcase
            default: v = {(q == 2'd0) || (q == 2'd3), !tx};
        endcase
        return v;
    endfunction

    always_comb begin
        r_d  = r_q;
        done = r_q.active && tick && (r_q.q == 2'd3);
        if (!r_q.active) begin
            if (cmd_valid) begin
                r_d.active = 1'b1;
                r_d.cmd    = cmd;
                r_d.tx     = tx_bit;
                r_d.q      = 2'd0;
                {r_d.scl_lo, r_d.sda_lo} = line_plan(cmd, 2'd0, tx_bit);
            end
        end else if (tick) begin
            if (r_q.q == 2'd3) begin
                r_d.active = 1'b0;
            end else begin
                r_d.q = r_q.q + 2'd1;
                {r_d.scl_lo, r_d.sda_lo} = line_plan(r_q.cmd, r_q.q + 2'd1, r_q.tx);
                if (r_q.q == 2'd2 && r_q.cmd == PH_BIT) r_d.rx = sda_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= PHY_RST;
        else        r_q <= r_d;
    end

    assign rx_bit = r_q.rx;
    assign scl_lo = r_q.scl_lo;
    assign sda_lo = r_q.sda_lo;

    AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.active |-> !cmd_valid); // R4

    AST_DATA_MOVES_UNDER_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.active && r_q.cmd == PH_BIT && !$stable(r_q.sda_lo)) |-> $past(r_q.scl_lo)); // R4
endmodule

// File: rtl/twb_master.sv
module twb_master
    import twb_pkg::*;
#(
    parameter int QTR_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       dat_we,
    input  logic [7:0] dat_wdata,
    output logic [7:0] dat_rdata,
    input  logic       int_we,
    input  logic [9:0] int_wdata,
    output logic [7:0] status,
    output logic       irq,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam eng_s ENG_RST = '{st: ST_IDLE, flag: 1'b0, status: SC_IDLE, aak: 1'b0,
                                 ien: 1'b0, ovr: 2'b00, data: 8'h00, txn: 1'b0,
                                 first: 1'b0, rd: 1'b0, bitcnt: 4'd0, issued: 1'b0};

    eng_s    r_q, r_d;
    logic    cmd_valid, tx_bit, phy_done, phy_rx, phy_scl_lo, phy_sda_lo;
    ph_cmd_e cmd;
    logic    rd_data, ack;
    logic    unused_bits;

    assign unused_bits = ^{ctl_wdata[7], ctl_wdata[1:0], int_wdata[7], int_wdata[5:0]};

    twb_bitphy #(.QTR_CYC(QTR_CYC)) u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd      (cmd),
        .tx_bit   (tx_bit),
        .sda_in   (sda_in),
        .done     (phy_done),
        .rx_bit   (phy_rx),
        .scl_lo   (phy_scl_lo),
        .sda_lo   (phy_sda_lo)
    );

    always_comb begin
        r_d       = r_q;
        rd_data   = r_q.rd && !r_q.first;
        ack       = !phy_rx;
        cmd_valid = (r_q.st inside {ST_START, ST_BYTE, ST_STOP}) && !r_q.issued;
        case (r_q.st)
            ST_START: cmd = PH_START;
            ST_STOP:  cmd = PH_STOP;
            default:  cmd = PH_BIT;
        endcase
        if (r_q.bitcnt < 4'd8) tx_bit = rd_data ? 1'b1 : r_q.data[7];
        else                   tx_bit = rd_data ? !r_q.aak : 1'b1;

        if (cmd_valid) r_d.issued = 1'b1;

        if (phy_done) begin
            r_d.issued = 1'b0;
            case (r_q.st)
                ST_START: begin
                    r_d.status = r_q.txn ? SC_RSTART : SC_START;
                    r_d.txn    = 1'b1;
                    r_d.first  = 1'b1;
                    r_d.flag   = 1'b1;
                    r_d.bitcnt = 4'd0;
                    r_d.st     = ST_WAIT;
                end
                ST_STOP: begin
                    r_d.status = SC_IDLE;
                    r_d.txn    = 1'b0;
                    r_d.first  = 1'b0;
                    r_d.rd     = 1'b0;
                    r_d.st     = ST_IDLE;
                end
                ST_BYTE: begin
                    if (r_q.bitcnt < 4'd8) begin
                        r_d.data   = {r_q.data[6:0], phy_rx};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else begin
                        r_d.bitcnt = 4'd0;
                        r_d.flag   = 1'b1;
                        r_d.first  = 1'b0;
                        r_d.st     = ST_WAIT;
                        if (r_q.first) begin
                            r_d.rd = r_q.data[0];
                            if (r_q.data[0]) r_d.status = ack ? SC_RADDR_ACK : SC_RADDR_NAK;
                            else             r_d.status = ack ? SC_WADDR_ACK : SC_WADDR_NAK;
                        end else if (r_q.rd) begin
                            r_d.status = r_q.aak ? SC_RDATA_ACK : SC_RDATA_NAK;
                        end else begin
                            r_d.status = ack ? SC_WDATA_ACK : SC_WDATA_NAK;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (int_we) begin
            r_d.ien = int_wdata[IB_IEN];
            r_d.ovr = {int_wdata[IB_SCLOV], int_wdata[IB_SDAOV]};
        end

        if (dat_we && (r_q.st inside {ST_IDLE, ST_WAIT})) r_d.data = dat_wdata;

        if (ctl_we && ctl_wdata[CB_EN]) begin
            if (r_q.st == ST_IDLE) begin
                if (ctl_wdata[CB_STA] && sda_in) begin
                    r_d.aak = ctl_wdata[CB_AAK];
                    r_d.st  = ST_START;
                end
            end else if (r_q.st == ST_WAIT && !ctl_wdata[CB_FLG]) begin
                r_d.flag = 1'b0;
                r_d.aak  = ctl_wdata[CB_AAK];
                if (ctl_wdata[CB_STA])      r_d.st = ST_START;
                else if (ctl_wdata[CB_STP]) r_d.st = ST_STOP;
                else                        r_d.st = ST_BYTE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= ENG_RST;
        else        r_q <= r_d;
    end

    assign ctl_rdata = {4'b0000, r_q.flag, r_q.aak, 2'b00};
    assign dat_rdata = r_q.data;
    assign status    = r_q.status;
    assign irq       = r_q.ien && r_q.flag;
    assign scl_oe    = phy_scl_lo || r_q.ovr[1];
    assign sda_oe    = phy_sda_lo || r_q.ovr[0];

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !ctl_we) |=> r_q.flag); // R8

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.flag && !ctl_we) |=> $stable(r_q.status)); // R8

    AST_CLOCK_PARKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.flag |-> phy_scl_lo); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (!phy_scl_lo && !phy_sda_lo)); // R7

    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> (r_q.status == SC_IDLE && !r_q.flag)); // R9
endmodule

// File: tb/twb_master_tb.sv
module twb_master_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = 8'h00;
    logic [7:0] dat_rdata;
    logic       int_we = 1'b0;
    logic [9:0] int_wdata = 10'h000;
    logic [7:0] status;
    logic       irq, scl_oe, sda_oe;

    // bus and target model
    logic s_sda_lo = 1'b0;
    logic stuck = 1'b0;
    logic scl_w, sda_w;
    assign scl_w = !scl_oe;
    assign sda_w = !(sda_oe || s_sda_lo || stuck);

    localparam logic [6:0] SLV = 7'h50;

    int         n_chk = 0;
    int         n_bad = 0;
    int         starts = 0;
    int         stops = 0;
    logic [7:0] last_rx = 8'h00;
    logic       s_mack = 1'b0;

    always #5 clk = !clk;

    twb_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .int_we(int_we), .int_wdata(int_wdata),
        .status(status), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_in(sda_w)
    );

    function automatic logic [7:0] rd_val(int idx);
        return (idx == 0) ? 8'hC3 : 8'h3C;
    endfunction

    // target: address 0x50, refuses data byte 0xEE, returns C3 then 3C
    initial begin
        logic       p_scl, p_sda, act, addr_ph, rd, ackme;
        logic [7:0] sh, cur;
        int         bitc, rd_idx;
        p_scl = 1'b1; p_sda = 1'b1; act = 1'b0; addr_ph = 1'b0; rd = 1'b0;
        ackme = 1'b0; sh = 8'h00; cur = 8'h00; bitc = 0; rd_idx = 0;
        forever begin
            @(scl_w or sda_w);
            if (scl_w && p_scl && !sda_w && p_sda) begin
                starts++; act = 1'b1; bitc = 0; addr_ph = 1'b1; rd = 1'b0; s_sda_lo = 1'b0;
            end else if (scl_w && p_scl && sda_w && !p_sda) begin
                stops++; act = 1'b0; bitc = 0; addr_ph = 1'b0; rd = 1'b0; s_sda_lo = 1'b0;
            end else if (act && scl_w && !p_scl) begin
                if (bitc < 8) sh = {sh[6:0], sda_w};
                else if (bitc == 8) s_mack = !sda_w;
                bitc++;
            end else if (act && !scl_w && p_scl) begin
                if (bitc == 8) begin
                    if (!rd) begin
                        last_rx = sh;
                        ackme = addr_ph ? (sh[7:1] == SLV) : (sh != 8'hEE);
                        s_sda_lo = ackme;
                    end else s_sda_lo = 1'b0;
                end else if (bitc == 9) begin
                    bitc = 0; s_sda_lo = 1'b0;
                    if (addr_ph) begin
                        addr_ph = 1'b0; rd = sh[0] && ackme; rd_idx = 0; cur = rd_val(0);
                    end else if (rd) begin
                        if (!s_mack) rd = 1'b0;
                        else begin rd_idx++; cur = rd_val(rd_idx); end
                    end
                    if (rd) s_sda_lo = !cur[7];
                end else if (bitc >= 1 && bitc <= 7 && rd) begin
                    s_sda_lo = !cur[7 - bitc];
                end
            end
            p_scl = scl_w; p_sda = sda_w;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wdata = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic wr_int(input logic [9:0] v);
        @(negedge clk); int_we = 1'b1; int_wdata = v;
        @(negedge clk); int_we = 1'b0;
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 3000 && !ctl_rdata[3]; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && status != 8'hF8; i++) @(negedge clk);
    endtask

    task automatic do_stop(input string req);
        int s0;
        s0 = stops;
        wr_ctl(8'h50);
        wait_idle();
        repeat (4) @(negedge clk);
        chk({req, " stop status"}, status, 8'hF8);
        chk({req, " stop flag"}, ctl_rdata[3], 1'b0);
        chk({req, " stop lines"}, {scl_oe, sda_oe}, 2'b00);
        chk({req, " stop seen"}, stops, s0 + 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 status", status, 8'hF8);
        chk("R1 flag", ctl_rdata[3], 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 lines", {scl_oe, sda_oe}, 2'b00);
    endtask

    task automatic t_no_enable();
        int s0;
        s0 = starts;
        wr_ctl(8'h20);
        repeat (100) @(negedge clk);
        chk("R12 status", status, 8'hF8);
        chk("R12 flag", ctl_rdata[3], 1'b0);
        chk("R12 lines", {scl_oe, sda_oe}, 2'b00);
        chk("R12 no start", starts, s0);
    endtask

    task automatic t_write();
        int s0;
        wr_int(10'h040);
        s0 = starts;
        wr_ctl(8'h60);
        wait_flag();
        chk("R2 status", status, 8'h08);
        chk("R2 start seen", starts, s0 + 1);
        chk("R2 clock held", scl_oe, 1'b1);
        chk("R10 irq set", irq, 1'b1);
        wr_ctl(8'h48);
        repeat (60) @(negedge clk);
        chk("R8 flag kept", ctl_rdata[3], 1'b1);
        chk("R8 status kept", status, 8'h08);
        wr_dat(8'hA0);
        wr_ctl(8'h40);
        chk("R8 flag cleared", ctl_rdata[3], 1'b0);
        chk("R10 irq cleared", irq, 1'b0);
        wait_flag();
        chk("R3 write addr ack", status, 8'h18);
        chk("R3 addr byte", last_rx, 8'hA0);
        wr_dat(8'h5A);
        wr_ctl(8'h40);
        wait_flag();
        chk("R4 data ack", status, 8'h28);
        chk("R4 byte on bus", last_rx, 8'h5A);
        chk("R4 data reg", dat_rdata, 8'h5A);
        wr_dat(8'hEE);
        wr_ctl(8'h40);
        wait_flag();
        chk("R4 data nack", status, 8'h30);
        do_stop("R7");
        chk("R10 irq after stop", irq, 1'b0);
        wr_int(10'h000);
    endtask

    task automatic t_addr_nack();
        wr_ctl(8'h60);
        wait_flag();
        wr_dat(8'h44);
        wr_ctl(8'h40);
        wait_flag();
        chk("R3 write addr nack", status, 8'h20);
        do_stop("R7");
    endtask

    task automatic t_read();
        wr_ctl(8'h60);
        wait_flag();
        wr_dat(8'hA1);
        wr_ctl(8'h40);
        wait_flag();
        chk("R3 read addr ack", status, 8'h40);
        wr_ctl(8'h44);
        wait_flag();
        chk("R5 acked read status", status, 8'h50);
        chk("R5 first byte", dat_rdata, 8'hC3);
        chk("R5 master ack", s_mack, 1'b1);
        wr_ctl(8'h40);
        wait_flag();
        chk("R5 last read status", status, 8'h58);
        chk("R5 second byte", dat_rdata, 8'h3C);
        chk("R5 master nack", s_mack, 1'b0);
        wr_ctl(8'h60);
        wait_flag();
        chk("R6 repeated start", status, 8'h10);
        do_stop("R7");
    endtask

    task automatic t_stuck();
        @(negedge clk); stuck = 1'b1;
        wr_ctl(8'h60);
        repeat (100) @(negedge clk);
        chk("R9 status", status, 8'hF8);
        chk("R9 flag", ctl_rdata[3], 1'b0);
        chk("R9 lines", {scl_oe, sda_oe}, 2'b00);
        @(negedge clk); stuck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_override();
        wr_int(10'h200);
        chk("R11 clock pulled", {scl_oe, sda_oe}, 2'b10);
        wr_int(10'h100);
        chk("R11 data pulled", {scl_oe, sda_oe}, 2'b01);
        wr_int(10'h300);
        chk("R11 both pulled", {scl_oe, sda_oe}, 2'b11);
        wr_int(10'h000);
        chk("R11 released", {scl_oe, sda_oe}, 2'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog all act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_no_enable();
        t_write();
        t_addr_nack();
        t_read();
        t_stuck();
        t_override();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule